// File: doc/BRIEF.md
# Console Test-Mode Step Sequencer

This block runs one operation at a time from the front-panel switch registers of an 18-bit word machine, instead of fetching from memory, while the console test-mode switch is on. Each step pulse takes the switch buffer word and splits it. The top two bits pick an operation and the low sixteen bits give an address `x`. The four operations are:

- store the toggle accumulator at `x`;
- read `x` and add it into the accumulator, leaving the word in the memory buffer so it can be examined;
- leave test mode and start normal execution at `x`;
- hand the whole word to an external operate unit.

Memory is reached through a single-port request/ready handshake with a separate write enable. The address register is loaded with `x` before any access. The accumulator adds in 18-bit ones' complement with end-around carry. After a transfer, the block stays idle until the test-mode switch is turned off and selected again.

Top module: `console_step_seq`

## Requirements
- R1: After reset, `busy`, `mem_req`, `opr_req` and `run_start` are low, and `ac`, `mbr`, `mar` and `pc` are zero.
- R2: A step pulse while `test_mode` is low has no effect: `busy` stays low, no request is raised and `mar` keeps its value.
- R3: An accepted step takes the operation from `sw_buf[17:16]` and loads `mar` with `sw_buf[15:0]` in the cycle after the step. `mem_addr` always equals `mar`.
- R4: Operation 00 loads `mbr` from `sw_acc`. It then raises `mem_req` with `mem_we` high, `mem_addr` equal to `x` and `mem_wdata` equal to that accumulator value, until `mem_ready` is seen.
- R5: Operation 01 raises `mem_req` with `mem_we` low. In the cycle `mem_ready` is high, `mbr` takes `mem_rdata`, and `ac` becomes the ones' complement sum of `ac` and `mem_rdata`. The sum is the 18-bit sum plus the carry out of bit 17.
- R6: Operation 10 loads `pc` with `x` and pulses `run_start` for exactly one cycle, with no memory request and without `busy` rising.
- R7: After operation 10, step pulses are ignored until `test_mode` has been low for at least one cycle and is high again.
- R8: Operation 11 raises `opr_req` with `opr_word` equal to the full switch word. Both are held, with `busy` high, until `opr_ack` is seen.
- R9: `busy` is high from the cycle after an accepted memory or operate step until the cycle after its completion. Step pulses that arrive while busy are ignored.
- R10: While `mem_req` waits for `mem_ready`, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | Console test-mode switch |
| step | input | 1 | One-cycle step request |
| sw_buf | input | 18 | Toggle switch buffer word (operation and address) |
| sw_acc | input | 18 | Toggle switch accumulator word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address (from MAR) |
| mem_wdata | output | 18 | Memory write data (from MBR) |
| mem_rdata | input | 18 | Memory read data |
| mem_ready | input | 1 | Memory access complete |
| opr_req | output | 1 | Operate request to external unit |
| opr_word | output | 18 | Operate word |
| opr_ack | input | 1 | Operate complete |
| ac | output | 18 | Accumulator |
| mbr | output | 18 | Memory buffer register |
| mar | output | 16 | Memory address register |
| pc | output | 16 | Program counter |
| busy | output | 1 | Operation in progress |
| run_start | output | 1 | One-cycle start of normal execution |

## Verification
The hardest situation to reach is a step pulse landing while a memory access is stalled with `mem_ready` low. To get there, the bench holds the memory ready off for several cycles and drives a transfer word with a step in the middle of the wait. It then confirms that `pc` and the run-start count do not move. The re-arm after a transfer also needs a deliberate switch sequence: the bench issues a step while the switch stays on, then drops `test_mode` for one cycle and raises it again before the next step.

// File: rtl/console_step_seq.sv
module console_step_seq #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              step,
  input  logic [WORD_W-1:0] sw_buf,
  input  logic [WORD_W-1:0] sw_acc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-3:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              opr_req,
  output logic [WORD_W-1:0] opr_word,
  input  logic              opr_ack,
  output logic [WORD_W-1:0] ac,
  output logic [WORD_W-1:0] mbr,
  output logic [WORD_W-3:0] mar,
  output logic [WORD_W-3:0] pc,
  output logic              busy,
  output logic              run_start
);
  localparam int ADDR_W = WORD_W - 2;
  localparam logic [1:0] OP_STO = 2'b00;
  localparam logic [1:0] OP_ADD = 2'b01;
  localparam logic [1:0] OP_TRN = 2'b10;
  localparam logic [1:0] OP_OPR = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_OPR} st_t;

  st_t         st;
  logic [1:0]  op;
  logic        armed;
  logic        take;
  logic [1:0]  sw_op;
  logic [ADDR_W-1:0] sw_x;
  logic [WORD_W:0]   raw_sum;
  logic [WORD_W-1:0] oc_sum;

  assign sw_op   = sw_buf[WORD_W-1 -: 2];
  assign sw_x    = sw_buf[ADDR_W-1:0];
  assign take    = step && test_mode && armed && (st == S_IDLE);
  assign raw_sum = {1'b0, ac} + {1'b0, mem_rdata};
  assign oc_sum  = raw_sum[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, raw_sum[WORD_W]};

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_MEM);
  assign mem_we    = (st == S_MEM) && (op == OP_STO);
  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign opr_req   = (st == S_OPR);
  assign opr_word  = mbr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op        <= OP_STO;
      armed     <= 1'b1;
      ac        <= '0;
      mbr       <= '0;
      mar       <= '0;
      pc        <= '0;
      run_start <= 1'b0;
    end else begin
      run_start <= 1'b0;
      if (!test_mode) armed <= 1'b1;
      case (st)
        S_IDLE: if (take) begin
          mar <= sw_x;
          op  <= sw_op;
          case (sw_op)
            OP_STO: begin mbr <= sw_acc; st <= S_MEM; end
            OP_ADD: st <= S_MEM;
            OP_TRN: begin pc <= sw_x; run_start <= 1'b1; armed <= 1'b0; end
            default: begin mbr <= sw_buf; st <= S_OPR; end
          endcase
        end
        S_MEM: if (mem_ready) begin
          if (op == OP_ADD) begin
            mbr <= mem_rdata;
            ac  <= oc_sum;
          end
          st <= S_IDLE;
        end
        S_OPR: if (opr_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  // R5
  add_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ready |=> mbr == $past(mem_rdata));

  // R6
  run_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |-> !busy && pc == $past(sw_buf[ADDR_W-1:0]) ##1 !run_start);

  // R8
  opr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opr_req && !opr_ack |=> opr_req && $stable(opr_word));

  // R9
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, opr_req, run_start}));

  // R2
  off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !test_mode |=> !busy && $stable(mar));
endmodule

// File: tb/console_step_seq_tb.sv
module console_step_seq_tb_top;
  localparam int W = 18;
  localparam logic [W-1:0] MASK = '1;

  logic clk = 1'b0, rst_n = 1'b0, test_mode = 1'b0, step = 1'b0;
  logic [W-1:0] sw_buf = '0, sw_acc = '0, mem_rdata = '0;
  logic mem_ready = 1'b0, opr_ack = 1'b0;
  logic mem_req, mem_we, opr_req, busy, run_start;
  logic [W-3:0] mem_addr, mar, pc;
  logic [W-1:0] mem_wdata, opr_word, ac, mbr;

  int checks = 0, errors = 0, rs_cnt = 0;
  bit done = 0;
  logic [W-1:0] exp_ac = '0;

  always #2.5 clk = ~clk;

  console_step_seq #(.WORD_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .step(step),
    .sw_buf(sw_buf), .sw_acc(sw_acc), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .opr_req(opr_req), .opr_word(opr_word),
    .opr_ack(opr_ack), .ac(ac), .mbr(mbr), .mar(mar), .pc(pc),
    .busy(busy), .run_start(run_start));

  always @(posedge clk) if (rst_n && run_start) rs_cnt <= rs_cnt + 1;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] oc_add(input logic [W-1:0] a, input logic [W-1:0] b);
    int unsigned s;
    s = int'(a) + int'(b);
    if (s > int'(MASK)) s = s - (int'(MASK) + 1) + 1;
    return W'(s);
  endfunction

  task automatic do_step(input logic [W-1:0] w);
    @(negedge clk); sw_buf = w; step = 1'b1;
    @(negedge clk); step = 1'b0;
  endtask

  task automatic serve(input int lat, input logic [W-1:0] rd);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk("R10 req held", {17'b0, mem_req}, 18'd1);
    end
    mem_rdata = rd; mem_ready = 1'b1;
    @(negedge clk); mem_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", {17'b0, busy}, 0);
    chk("R1 req", {16'b0, mem_req, opr_req}, 0);
    chk("R1 ac", ac, 0);
    chk("R1 mbr", mbr, 0);
    chk("R1 mar pc", {2'b0, mar | pc}, 0);

    do_step({2'b01, 16'h1234});
    chk("R2 busy off", {17'b0, busy}, 0);
    chk("R2 mar off", {2'b0, mar}, 0);
    test_mode = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      logic [15:0] x; logic [W-1:0] t;
      x = 16'(16'hA5C3 ^ (i * 16'h1111));
      t = W'(i * 18'h0B5A7) ^ (W'(i) << 11);
      sw_acc = t;
      do_step({2'b00, x});
      chk("R3 mar", {2'b0, mar}, {2'b0, x});
      chk("R3 mem_addr", {2'b0, mem_addr}, {2'b0, x});
      chk("R4 we", {16'b0, mem_req, mem_we}, 18'd3);
      chk("R4 wdata", mem_wdata, t);
      chk("R9 busy", {17'b0, busy}, 1);
      sw_acc = ~t;
      serve(i % 4, '0);
      chk("R9 idle", {17'b0, busy}, 0);
      chk("R4 mbr", mbr, t);
    end

    for (int i = 0; i < 12; i++) begin
      logic [W-1:0] v;
      v = (i == 0) ? MASK : (i == 1) ? 18'h20000 : (i == 2) ? 18'h00001 :
          W'(i * 18'h1D3F5) ^ (W'(i) << 13);
      do_step({2'b01, 16'(i * 16'h0101)});
      chk("R5 rd", {16'b0, mem_req, mem_we}, 18'd2);
      serve(i % 3, v);
      exp_ac = oc_add(exp_ac, v);
      chk("R5 mbr", mbr, v);
      chk("R5 ac", ac, exp_ac);
    end

    begin
      int rs0;
      rs0 = rs_cnt;
      do_step({2'b01, 16'h0042});
      @(negedge clk);
      sw_buf = {2'b10, 16'hBEEF}; step = 1'b1;
      @(negedge clk); step = 1'b0;
      serve(1, 18'h00003);
      exp_ac = oc_add(exp_ac, 18'h00003);
      chk("R9 pc kept", {2'b0, pc}, 0);
      chk("R9 no run", 18'(rs_cnt - rs0), 0);
      chk("R9 ac", ac, exp_ac);
    end

    for (int i = 0; i < 3; i++) begin
      logic [W-1:0] w;
      w = {2'b11, 16'(16'h7E01 + i * 16'h3333)};
      do_step(w);
      chk("R8 req", {17'b0, opr_req}, 1);
      chk("R8 word", opr_word, w);
      repeat (i + 1) @(negedge clk);
      chk("R8 held", {17'b0, opr_req & busy}, 1);
      opr_ack = 1'b1;
      @(negedge clk); opr_ack = 1'b0;
      chk("R8 done", {17'b0, busy | opr_req}, 0);
    end

    for (int i = 0; i < 4; i++) begin
      logic [15:0] x; int rs0;
      x = 16'(16'h0F00 + i * 16'h2345);
      rs0 = rs_cnt;
      @(negedge clk); sw_buf = {2'b10, x}; step = 1'b1;
      @(negedge clk); step = 1'b0;
      chk("R6 run", {17'b0, run_start}, 1);
      chk("R6 pc", {2'b0, pc}, {2'b0, x});
      chk("R6 no busy", {16'b0, busy, mem_req}, 0);
      @(negedge clk);
      chk("R6 pulse", 18'(rs_cnt - rs0), 1);
      do_step({2'b01, 16'h0005});
      chk("R7 ignored", {16'b0, busy, mem_req}, 0);
      test_mode = 1'b0; @(negedge clk); test_mode = 1'b1;
      do_step({2'b01, 16'h0006});
      chk("R7 rearmed", {17'b0, mem_req}, 1);
      serve(0, 18'h00010);
      exp_ac = oc_add(exp_ac, 18'h00010);
      chk("R7 ac", ac, exp_ac);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule